// File: doc/BRIEF.md
# Parallel EPROM Byte-Read Controller

This block sits on the host side of an asynchronous 128K x 8 parallel EPROM and turns a single-cycle read request into a correctly timed read cycle. When a request is taken, it drives the 17-bit address and pulls the active-low chip enable low. It then counts clock cycles until three separate access paths are all covered: address to data, chip enable to data, and output enable to data. At that point it samples the 8-bit data bus and returns the byte with a one-cycle valid strobe.

Each path's wait is derived from a time parameter in nanoseconds and the clock-period parameter. A wait is the time divided by the period, rounded up, and never less than one cycle. Output enable is not asserted together with chip enable. It is held back by (chip-enable cycles minus output-enable cycles), the latest point that still meets the chip-enable access time, so the data bus is driven for the shortest possible window. A busy/ready handshake holds off new requests while a read is in progress.

Between reads the device is left selected with its outputs disabled. After a configurable number of idle cycles, chip enable is released and the part drops into standby. The program strobe is held high at all times.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: The asynchronous reset (rstN low) immediately forces romCeN=1, romOeN=1 and rdValid=0, and reqReady=1, even in the middle of a read.
- R2: When reqValid and reqReady are both high at a rising clock edge, the request is accepted at that edge. From that edge on, romAddr equals the requested address, romCeN=0 and reqReady=0.
- R3: romOeN falls exactly OE_DELAY edges after the accept edge. OE_DELAY = ceil(T_CE_NS/CLK_PERIOD_NS) - ceil(T_OE_NS/CLK_PERIOD_NS), floored at 0. With the defaults (8 ns period, 90/90/30 ns) this is 12-4 = 8.
- R4: The data bus is sampled at edge SAMPLE_CYC after the accept edge, and rdData shows that byte while rdValid is high for exactly one cycle from that edge. SAMPLE_CYC is the maximum of the address wait, the chip-enable wait and OE_DELAY plus the output-enable wait, each wait being ceil(time/period) with a minimum of 1. With the defaults this is 12.
- R5: romOeN returns high at the sampling edge. romAddr does not change from the accept edge until the next accept, and romCeN stays low after the read (outputs disabled, device still selected).
- R6: reqReady stays low from the accept edge until the sampling edge, and reqValid has no effect during that time: romAddr keeps the accepted address.
- R7: reqReady is high while rdValid is high, so a request waiting in that cycle is accepted one cycle after the strobe rises. Its address then appears on romAddr at the next edge.
- R8: After IDLE_CYCLES consecutive cycles with no accepted request following a read, romCeN goes high (standby), and romOeN is high whenever romCeN is high. With the default of 16, romCeN is still low 15 edges after the sampling edge and high at the 16th.
- R9: A read started from standby has the same OE_DELAY and SAMPLE_CYC timing and returns correct data.
- R10: romPgmN is held high at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request present |
| reqAddr | input | 17 | Byte address of the request |
| reqReady | output | 1 | Controller can accept a request this cycle |
| rdValid | output | 1 | One-cycle strobe: rdData holds the read byte |
| rdData | output | 8 | Captured byte |
| romAddr | output | 17 | Address lines to the EPROM |
| romCeN | output | 1 | Active-low chip enable |
| romOeN | output | 1 | Active-low output enable |
| romPgmN | output | 1 | Active-low program strobe, tied inactive |
| romData | input | 8 | Data lines from the EPROM |

## Verification
The bench drives a memory model that returns a junk byte until all three access windows, measured in its own cycle counts, have elapsed. A controller that rounds a wait down, samples one edge early, or enables the outputs too early captures the junk byte or shows the output-enable fall at the wrong edge. Back-to-back requests target the busy window: a design that lets a pending request slip in early changes the address mid-access, and one that stalls an extra cycle delays the second address. The idle countdown is probed one edge either side of standby entry. An asynchronous reset issued mid-access must release the device at once rather than at the next edge.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  // Strobes from the sequencer to the datapath, valid for one clock.
  typedef struct packed {
    logic loadAddr;   // latch request address onto the bus
    logic ceOn;       // select the device
    logic ceOff;      // release the device into standby
    logic oeOn;       // enable the device's output drivers
    logic oeOff;      // disable the device's output drivers
    logic capture;    // sample the data bus and raise the valid strobe
  } rdCtrl_t;

  // Clock cycles needed to cover a delay: rounded up, at least one.
  function automatic int waitCycles(input int delayNs, input int periodNs);
    int c;
    c = (delayNs + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eprom_rd_fsm.sv
module eprom_rd_fsm
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_CYC    = 12,
  parameter int CE_CYC      = 12,
  parameter int OE_CYC      = 4,
  parameter int IDLE_CYCLES = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  output rdCtrl_t ctrl
);

  // Output enable is deferred as late as the chip-enable path allows.
  localparam int OE_DELAY   = (CE_CYC > OE_CYC) ? (CE_CYC - OE_CYC) : 0;
  localparam int SAMPLE_CYC = maxOf(maxOf(ADDR_CYC, CE_CYC), OE_DELAY + OE_CYC);
  localparam int CNT_W      = $clog2(SAMPLE_CYC + 1);
  localparam int IDLE_W     = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;

  typedef enum logic {ST_IDLE, ST_ACCESS} rdState_t;

  rdState_t          state;
  logic [CNT_W-1:0]  accCnt;
  logic [CNT_W-1:0]  elapsed;
  logic [IDLE_W-1:0] idleCnt;
  logic              standby;
  logic              accept;
  logic              sampleHit;
  logic              idleExpire;
  logic              oeHit;

  assign accept     = (state == ST_IDLE) && reqValid;
  assign elapsed    = accCnt + 1'b1;
  assign sampleHit  = (state == ST_ACCESS) && (elapsed == CNT_W'(SAMPLE_CYC));
  assign idleExpire = (state == ST_IDLE) && !accept && !standby &&
                      (idleCnt == IDLE_W'(IDLE_CYCLES - 1));

  generate
    if (OE_DELAY == 0) begin : g_oeWithCe
      assign oeHit = accept;
    end else begin : g_oeDeferred
      assign oeHit = (state == ST_ACCESS) && (elapsed == CNT_W'(OE_DELAY));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      accCnt  <= '0;
      idleCnt <= '0;
      standby <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_ACCESS;
            accCnt  <= '0;
            standby <= 1'b0;
          end else if (!standby) begin
            if (idleExpire) begin
              standby <= 1'b1;
              idleCnt <= '0;
            end else begin
              idleCnt <= idleCnt + 1'b1;
            end
          end
        end
        ST_ACCESS: begin
          if (sampleHit) begin
            state   <= ST_IDLE;
            idleCnt <= '0;
          end else begin
            accCnt <= elapsed;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady      = (state == ST_IDLE);
    ctrl          = '0;
    ctrl.loadAddr = accept;
    ctrl.ceOn     = accept;
    ctrl.ceOff    = idleExpire;
    ctrl.oeOn     = oeHit;
    ctrl.oeOff    = sampleHit;
    ctrl.capture  = sampleHit;
  end

endmodule

// File: rtl/eprom_rd_dp.sv
module eprom_rd_dp
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romCeN,
  output logic              romOeN,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romAddr <= '0;
    end else if (ctrl.loadAddr) begin
      romAddr <= reqAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romCeN <= 1'b1;
    end else if (ctrl.ceOn) begin
      romCeN <= 1'b0;
    end else if (ctrl.ceOff) begin
      romCeN <= 1'b1;
    end
  end

  // Output drivers never stay on once the device is released.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romOeN <= 1'b1;
    end else if (ctrl.oeOn) begin
      romOeN <= 1'b0;
    end else if (ctrl.oeOff || ctrl.ceOff) begin
      romOeN <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= ctrl.capture;
      if (ctrl.capture) rdData <= romData;
    end
  end

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_ADDR_NS     = 90,
  parameter int T_CE_NS       = 90,
  parameter int T_OE_NS       = 30,
  parameter int IDLE_CYCLES   = 16,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romCeN,
  output logic              romOeN,
  output logic              romPgmN,
  input  logic [DATA_W-1:0] romData
);

  localparam int ADDR_CYC = waitCycles(T_ADDR_NS, CLK_PERIOD_NS);
  localparam int CE_CYC   = waitCycles(T_CE_NS, CLK_PERIOD_NS);
  localparam int OE_CYC   = waitCycles(T_OE_NS, CLK_PERIOD_NS);

  rdCtrl_t ctrl;

  assign romPgmN = 1'b1;

  eprom_rd_fsm #(
    .ADDR_CYC   (ADDR_CYC),
    .CE_CYC     (CE_CYC),
    .OE_CYC     (OE_CYC),
    .IDLE_CYCLES(IDLE_CYCLES)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .ctrl    (ctrl)
  );

  eprom_rd_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .reqAddr(reqAddr),
    .romData(romData),
    .romAddr(romAddr),
    .romCeN (romCeN),
    .romOeN (romOeN),
    .rdValid(rdValid),
    .rdData (rdData)
  );

endmodule

// File: rtl/eprom_rd_chk.sv
module eprom_rd_chk
  import eprom_rd_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_ADDR_NS     = 90,
  parameter int T_CE_NS       = 90,
  parameter int T_OE_NS       = 30,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqReady,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic [ADDR_W-1:0] romAddr,
  input logic              romCeN,
  input logic              romOeN,
  input logic [DATA_W-1:0] romData
);

  localparam int A_CYC  = waitCycles(T_ADDR_NS, CLK_PERIOD_NS);
  localparam int C_CYC  = waitCycles(T_CE_NS, CLK_PERIOD_NS);
  localparam int O_CYC  = waitCycles(T_OE_NS, CLK_PERIOD_NS);
  localparam int DLY    = (C_CYC > O_CYC) ? (C_CYC - O_CYC) : 0;
  localparam int SMP    = maxOf(maxOf(A_CYC, C_CYC), DLY + O_CYC);

  // Edges seen since the accept edge, counted independently of the design.
  int sinceAcc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     sinceAcc <= 0;
    else if (reqValid && reqReady) sinceAcc <= 1;
    else if (!reqReady)            sinceAcc <= sinceAcc + 1;
  end

  AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!romCeN && !reqReady && romAddr == $past(reqAddr))); // R2

  AST_OE_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    $fell(romOeN) |-> (sinceAcc == DLY + 1)); // R3

  AST_SAMPLE_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> (sinceAcc == SMP + 1)); // R4

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R4

  AST_CAPTURED_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData == $past(romData))); // R4

  AST_OE_OFF_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> romOeN); // R5

  AST_ADDR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> $stable(romAddr)); // R6

  AST_READY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> reqReady); // R7

  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    romCeN |-> romOeN); // R8

endmodule

bind eprom_rd_ctrl eprom_rd_chk #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_ADDR_NS    (T_ADDR_NS),
  .T_CE_NS      (T_CE_NS),
  .T_OE_NS      (T_OE_NS),
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqAddr (reqAddr),
  .reqReady(reqReady),
  .rdValid (rdValid),
  .rdData  (rdData),
  .romAddr (romAddr),
  .romCeN  (romCeN),
  .romOeN  (romOeN),
  .romData (romData)
);

// File: tb/eprom_rd_ctrl_test.sv
`timescale 1ns/1ps
module eprom_rd_ctrl_test;

  localparam int PERIOD = 8;
  localparam int IDLE_N = 16;
  localparam logic [7:0] JUNK = 8'h3C;

  // Expected counts, worked out from the requirements.
  function automatic int ceilCyc(input int t);
    int c;
    c = (t + PERIOD - 1) / PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int EA = ceilCyc(90);
  localparam int EC = ceilCyc(90);
  localparam int EO = ceilCyc(30);
  localparam int ED = EC - EO;
  localparam int ES = (EA > EC ? (EA > ED + EO ? EA : ED + EO) : (EC > ED + EO ? EC : ED + EO));

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [16:0] reqAddr = '0;
  logic        reqReady, rdValid, romCeN, romOeN, romPgmN;
  logic [7:0]  rdData, romData;
  logic [16:0] romAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  eprom_rd_ctrl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rdValid(rdValid), .rdData(rdData),
    .romAddr(romAddr), .romCeN(romCeN), .romOeN(romOeN),
    .romPgmN(romPgmN), .romData(romData)
  );

  function automatic logic [7:0] pattern(input logic [16:0] a);
    return a[7:0] ^ a[16:9] ^ 8'h11;
  endfunction

  // Memory model: real data only once all three windows have elapsed.
  logic [16:0] seenAddr = 'x;
  int addrAge = 0, ceAge = -1, oeAge = -1;
  always @(negedge clk) begin
    if (romAddr !== seenAddr) begin seenAddr = romAddr; addrAge = 0; end
    else if (addrAge < 1000) addrAge++;
    if (romCeN !== 1'b0) ceAge = -1; else if (ceAge < 1000) ceAge++;
    if (romOeN !== 1'b0) oeAge = -1; else if (oeAge < 1000) oeAge++;
    if (ceAge >= 0 && oeAge >= 0 && addrAge + 1 >= EA && ceAge + 1 >= EC && oeAge + 1 >= EO)
      romData = pattern(romAddr);
    else
      romData = JUNK;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(romCeN == 1'b1, "R1 ceN", romCeN, 1);
    check(romOeN == 1'b1, "R1 oeN", romOeN, 1);
    check(rdValid == 1'b0, "R1 rdValid", rdValid, 0);
    check(reqReady == 1'b1, "R1 reqReady", reqReady, 1);
    check(romPgmN == 1'b1, "R10 pgmN", romPgmN, 1);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Issue one read and follow it edge by edge until the strobe.
  task automatic runRead(input logic [16:0] addr, input string tag);
    int oeAt = -1;
    int valAt = -1;
    bit busyOk = 1'b1;
    reqValid = 1'b1; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    check(romAddr == addr, {tag, " R2 addr"}, romAddr, addr);
    check(romCeN == 1'b0, {tag, " R2 ceN"}, romCeN, 0);
    for (int k = 0; k < 64; k++) begin
      if (k > 0) @(negedge clk);
      if (!romOeN && oeAt < 0) oeAt = k;
      if (rdValid) begin valAt = k; break; end
      if (reqReady) busyOk = 1'b0;
    end
    check(busyOk, {tag, " R6 busy"}, busyOk, 1);
    check(oeAt == ED, {tag, " R3 oe edge"}, oeAt, ED);
    check(valAt == ES, {tag, " R4 sample edge"}, valAt, ES);
    check(rdData == pattern(addr), {tag, " R4 data"}, rdData, pattern(addr));
    check(romOeN == 1'b1, {tag, " R5 oe off"}, romOeN, 1);
    check(romCeN == 1'b0 && romAddr == addr, {tag, " R5 hold"}, romAddr, addr);
    check(reqReady == 1'b1, {tag, " R7 ready"}, reqReady, 1);
    check(romPgmN == 1'b1, {tag, " R10 pgmN"}, romPgmN, 1);
    @(negedge clk);
    check(rdValid == 1'b0, {tag, " R4 one cycle"}, rdValid, 0);
  endtask

  // Entered on the negedge one cycle after the strobe (edge ES+1).
  task automatic testStandby();
    repeat (IDLE_N - 2) @(negedge clk);
    check(romCeN == 1'b0, "R8 still selected", romCeN, 0);
    @(negedge clk);
    check(romCeN == 1'b1, "R8 standby", romCeN, 1);
    check(romOeN == 1'b1, "R8 oe off in standby", romOeN, 1);
  endtask

  task automatic testBackToBack(input logic [16:0] a1, input logic [16:0] a2);
    bit held = 1'b1;
    int valAt = -1;
    reqValid = 1'b1; reqAddr = a1;
    @(negedge clk);
    reqAddr = a2;
    for (int k = 0; k < 64; k++) begin
      if (k > 0) @(negedge clk);
      if (romAddr != a1) held = 1'b0;
      if (rdValid) begin valAt = k; break; end
    end
    check(held, "R6 ignored while busy", held, 1);
    check(valAt == ES && rdData == pattern(a1), "R4 b2b first", rdData, pattern(a1));
    @(negedge clk);
    reqValid = 1'b0;
    check(romAddr == a2 && !romCeN && !reqReady, "R7 next accept", romAddr, a2);
    valAt = -1;
    for (int k = 0; k < 64; k++) begin
      if (k > 0) @(negedge clk);
      if (rdValid) begin valAt = k; break; end
    end
    check(valAt == ES, "R7 b2b second timing", valAt, ES);
    check(rdData == pattern(a2), "R7 b2b second data", rdData, pattern(a2));
  endtask

  task automatic testResetMidRead(input logic [16:0] a);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (ED + 1) @(negedge clk);
    check(romOeN == 1'b0, "R1 pre-reset oe on", romOeN, 0);
    rstN = 1'b0;
    #1;
    check(romCeN == 1'b1 && romOeN == 1'b1, "R1 async release", {romCeN, romOeN}, 3);
    check(reqReady == 1'b1 && rdValid == 1'b0, "R1 async idle", {reqReady, rdValid}, 2);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    testReset();
    runRead(17'h1_2345, "first");
    testStandby();
    runRead(17'h0_0AF0, "from standby R9");
    testBackToBack(17'h1_FFFF, 17'h0_0001);
    testResetMidRead(17'h0_5A5A);
    runRead(17'h1_0000, "after reset");
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * PERIOD);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule